// File: doc/BRIEF.md
# LPC I/O Read Target

This block sits on the peripheral side of a Low Pin Count bus and answers host I/O read cycles. Every rising edge of the bus clock it samples the frame strobe and the four multiplexed address/data lines. It recognises a start nibble, checks the cycle-type nibble and gathers a 16-bit port address one nibble per clock. When that address hits one of its two configured ports, it waits out the host turnaround and then takes over the lines. It drives a SYNC acknowledge, one byte split into two nibbles, and its own turnaround pattern. After that it lets go of the bus.

The data port returns a byte held in an output buffer that a local processor fills. Each write to that buffer raises an output-buffer-full flag. A finished host read of the data port drops the flag and fires a one-clock empty interrupt toward the local side. The status port returns a status byte. Bit 0 of that byte mirrors the buffer-full flag, and the upper seven bits come from a local input. Reading the status port does not change the flag or the interrupt. The local write port runs on the bus clock.

Top module: `lpc_io_read_target`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the LAD output enable is low, the buffer-full flag is 0 and the interrupt is 0.
- R2: A transaction starts only when LFRAME# is low and LAD is 0000 at a rising edge. In the next cycle LFRAME# must be high and LAD[3:1] must be 000 (I/O read; bit 0 is ignored). The next four nibbles form the address, most significant nibble first.
- R3: Through the eight host-driven cycles the target leaves LAD undriven. In cycle 9 it first drives LAD, with 0000 (SYNC ready).
- R4: For a data-port read, cycle 10 carries buffer bits 3:0 and cycle 11 carries buffer bits 7:4.
- R5: In cycle 12 the target drives 1111. In cycle 13 the LAD output enable is low again.
- R6: During cycle 12 of a data-port read the buffer-full flag reads 0 and the interrupt is 1. The interrupt lasts exactly one clock.
- R7: A local write loads the output buffer and sets the buffer-full flag from the following cycle. A write in the cycle whose closing edge ends a data-port read takes priority, so the flag stays 1.
- R8: A status-port read returns the byte {status_hi[6:0], flag} low nibble first. It leaves the flag unchanged and produces no interrupt.
- R9: When the assembled address matches neither port, the target never drives LAD. It then serves the next valid transaction. The nibble-reversed data-port address counts as a mismatch.
- R10: When the cycle-type nibble is not an I/O read (for example 0010), the target never drives LAD.
- R11: When LFRAME# is low with a start nibble other than 0000, no transaction starts and LAD is never driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lclk | input | 1 | Bus clock; all sampling on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lframe_n | input | 1 | Frame strobe, low marks a start |
| lad_in | input | 4 | Sampled value of the LAD lines |
| lad_out | output | 4 | Value the target drives onto LAD |
| lad_oe | output | 1 | High while the target drives LAD |
| cpu_wr | input | 1 | Local write strobe for the output buffer |
| cpu_wdata | input | 8 | Local write data |
| status_hi | input | 7 | Upper seven bits of the status byte |
| obuf_full | output | 1 | Output-buffer-full flag |
| obuf_empty_irq | output | 1 | One-clock empty interrupt |

## Verification
Data-port reads use two different buffer bytes with distinct nibbles. This shows whether the low and high halves come out in the right order and whether the flag and interrupt move in cycle 12. Status-port reads are made with the flag both clear and set. They separate the status path from the buffer path and confirm that such a read leaves the flag alone. Negative patterns check that the target stays silent and remains ready for the next cycle: a nibble-reversed address, a write cycle type and a wrong start code. A local write timed to the last edge of a read tests priority between setting and clearing the flag.

// File: rtl/lpc_rd_pkg.sv
package lpc_rd_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_TYPE,
    S_ADDR,
    S_HTAR1,
    S_HTAR2,
    S_SYNC,
    S_DLO,
    S_DHI,
    S_TTAR1,
    S_TTAR2
  } rd_state_e;

  localparam logic [3:0] NIB_START = 4'h0;
  localparam logic [3:0] NIB_SYNC  = 4'h0;
  localparam logic [3:0] NIB_TAR   = 4'hF;

endpackage

// File: rtl/lpc_rd_fsm.sv
module lpc_rd_fsm
  import lpc_rd_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] DATA_PORT = 16'h0060,
  parameter logic [15:0] STAT_PORT = 16'h0064
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      lframe_n,
  input  logic [3:0] lad_in,
  output rd_state_e state,
  output logic      sel_data
);

  localparam int NIBS  = ADDR_W / 4;
  localparam int CNT_W = (NIBS > 1) ? $clog2(NIBS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NIBS - 1);

  rd_state_e          state_q, state_d;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               sel_q, sel_d;
  logic [ADDR_W-1:0]  addr_full;
  logic               hit_data, hit_stat;

  assign addr_full = {addr_q[ADDR_W-5:0], lad_in};
  assign hit_data  = (addr_full == DATA_PORT[ADDR_W-1:0]);
  assign hit_stat  = (addr_full == STAT_PORT[ADDR_W-1:0]);

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    cnt_d   = cnt_q;
    sel_d   = sel_q;
    unique case (state_q)
      S_IDLE:  if (!lframe_n && lad_in == NIB_START) state_d = S_TYPE;
      S_TYPE: begin
        if (lframe_n && lad_in[3:1] == 3'b000) begin
          state_d = S_ADDR;
          cnt_d   = '0;
        end else begin
          state_d = S_IDLE;
        end
      end
      S_ADDR: begin
        addr_d = addr_full;
        cnt_d  = cnt_q + 1'b1;
        if (cnt_q == CNT_LAST) begin
          if (hit_data || hit_stat) begin
            state_d = S_HTAR1;
            sel_d   = hit_data;
          end else begin
            state_d = S_IDLE;
          end
        end
      end
      S_HTAR1: state_d = S_HTAR2;
      S_HTAR2: state_d = S_SYNC;
      S_SYNC:  state_d = S_DLO;
      S_DLO:   state_d = S_DHI;
      S_DHI:   state_d = S_TTAR1;
      S_TTAR1: state_d = S_TTAR2;
      S_TTAR2: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      cnt_q   <= '0;
      sel_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == S_ADDR) addr_q <= addr_d;
      if (state_q == S_ADDR || state_q == S_TYPE) cnt_q <= cnt_d;
      if (state_q == S_ADDR) sel_q <= sel_d;
    end
  end

  assign state    = state_q;
  assign sel_data = sel_q;

  // R2: the address phase is entered only from the cycle-type phase
  a_r2_addr_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_ADDR && $past(state_q) != S_ADDR) |-> $past(state_q) == S_TYPE);

endmodule

// File: rtl/lpc_rd_drive.sv
module lpc_rd_drive
  import lpc_rd_pkg::*;
(
  input  rd_state_e  state,
  input  logic       sel_data,
  input  logic [7:0] obuf,
  input  logic [7:0] status,
  output logic [3:0] lad_out,
  output logic       lad_oe
);

  logic [7:0] byte_sel;

  assign byte_sel = sel_data ? obuf : status;

  always_comb begin
    lad_out = 4'h0;
    lad_oe  = 1'b0;
    unique case (state)
      S_SYNC:  begin lad_oe = 1'b1; lad_out = NIB_SYNC;      end
      S_DLO:   begin lad_oe = 1'b1; lad_out = byte_sel[3:0]; end
      S_DHI:   begin lad_oe = 1'b1; lad_out = byte_sel[7:4]; end
      S_TTAR1: begin lad_oe = 1'b1; lad_out = NIB_TAR;       end
      default: begin lad_oe = 1'b0; lad_out = 4'h0;          end
    endcase
  end

endmodule

// File: rtl/lpc_rd_flags.sv
module lpc_rd_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_wr,
  input  logic [7:0] cpu_wdata,
  input  logic       rd_done,
  output logic [7:0] obuf,
  output logic       obf,
  output logic       irq
);

  logic [7:0] obuf_q;
  logic       obf_q, obf_d;
  logic       irq_q;

  always_comb begin
    obf_d = obf_q;
    if (rd_done) obf_d = 1'b0;
    if (cpu_wr)  obf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      obuf_q <= '0;
      obf_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (cpu_wr) obuf_q <= cpu_wdata;
      obf_q <= obf_d;
      irq_q <= rd_done;
    end
  end

  assign obuf = obuf_q;
  assign obf  = obf_q;
  assign irq  = irq_q;

  // R6: interrupt is a single-clock pulse
  a_r6_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);

  // R6: interrupt coincides with a cleared flag unless a write raced it
  a_r6_irq_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !$past(cpu_wr)) |-> !obf_q);

  // R7: a local write always leaves the flag set
  a_r7_write_sets: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr |=> obf_q);

endmodule

// File: rtl/lpc_io_read_target.sv
module lpc_io_read_target
  import lpc_rd_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] DATA_PORT = 16'h0060,
  parameter logic [15:0] STAT_PORT = 16'h0064
) (
  input  logic       lclk,
  input  logic       rst_n,
  input  logic       lframe_n,
  input  logic [3:0] lad_in,
  output logic [3:0] lad_out,
  output logic       lad_oe,
  input  logic       cpu_wr,
  input  logic [7:0] cpu_wdata,
  input  logic [6:0] status_hi,
  output logic       obuf_full,
  output logic       obuf_empty_irq
);

  rd_state_e  state;
  logic       sel_data;
  logic [7:0] obuf;
  logic [7:0] status;
  logic       rd_done;
  logic       obf;

  assign rd_done = (state == S_DHI) && sel_data;
  assign status  = {status_hi, obf};

  lpc_rd_fsm #(
    .ADDR_W    (ADDR_W),
    .DATA_PORT (DATA_PORT),
    .STAT_PORT (STAT_PORT)
  ) u_fsm (
    .clk      (lclk),
    .rst_n    (rst_n),
    .lframe_n (lframe_n),
    .lad_in   (lad_in),
    .state    (state),
    .sel_data (sel_data)
  );

  lpc_rd_drive u_drive (
    .state    (state),
    .sel_data (sel_data),
    .obuf     (obuf),
    .status   (status),
    .lad_out  (lad_out),
    .lad_oe   (lad_oe)
  );

  lpc_rd_flags u_flags (
    .clk       (lclk),
    .rst_n     (rst_n),
    .cpu_wr    (cpu_wr),
    .cpu_wdata (cpu_wdata),
    .rd_done   (rd_done),
    .obuf      (obuf),
    .obf       (obf),
    .irq       (obuf_empty_irq)
  );

  assign obuf_full = obf;

  // R3: the first driven nibble of every answer is SYNC ready
  a_r3_first_sync: assert property (@(posedge lclk) disable iff (!rst_n)
    $rose(lad_oe) |-> lad_out == NIB_SYNC);

  // R5: the target lets go of LAD only after driving 1111
  a_r5_tail_ones: assert property (@(posedge lclk) disable iff (!rst_n)
    $fell(lad_oe) |-> $past(lad_out) == NIB_TAR);

endmodule

// File: tb/lpc_io_read_target_bench.sv
module lpc_io_read_target_bench;

  logic       clk;
  logic       rst_n;
  logic       lframe_n;
  logic [3:0] lad_in;
  logic [3:0] lad_out;
  logic       lad_oe;
  logic       cpu_wr;
  logic [7:0] cpu_wdata;
  logic [6:0] status_hi;
  logic       obuf_full;
  logic       obuf_empty_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [3:0] exp_q[$];
  string      tag_q[$];

  localparam logic [15:0] DPORT = 16'h0060;
  localparam logic [15:0] SPORT = 16'h0064;

  lpc_io_read_target u_lpc_io_read_target (
    .lclk           (clk),
    .rst_n          (rst_n),
    .lframe_n       (lframe_n),
    .lad_in         (lad_in),
    .lad_out        (lad_out),
    .lad_oe         (lad_oe),
    .cpu_wr         (cpu_wr),
    .cpu_wdata      (cpu_wdata),
    .status_hi      (status_hi),
    .obuf_full      (obuf_full),
    .obuf_empty_irq (obuf_empty_irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: every driven nibble must match the next scoreboard entry
  always @(negedge clk) begin
    if (rst_n && lad_oe) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R3/R9/R10/R11 unexpected drive actual=%h expected=no drive", lad_out);
      end else begin
        automatic logic [3:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (lad_out !== e) begin
          fails++;
          $display("FAIL %s actual=%h expected=%h", t, lad_out, e);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic cpu_write(logic [7:0] b);
    cpu_wr    = 1'b1;
    cpu_wdata = b;
    step();
    cpu_wr    = 1'b0;
    check("R7 flag after write", {7'd0, obuf_full}, 8'h01);
  endtask

  // Host cycle: start nibble, type nibble, address, host turnaround.
  // answer: 0 none, 1 data port, 2 status port.
  task automatic host_read(logic [3:0] start, logic [3:0] ctype, logic [15:0] addr,
                           int answer, logic [7:0] byte_exp, bit wr_race);
    automatic logic flag_before = obuf_full;
    lframe_n = 1'b0; lad_in = start; step();
    lframe_n = 1'b1; lad_in = ctype; step();
    for (int i = 3; i >= 0; i--) begin
      lad_in = addr[i*4 +: 4];
      step();
    end
    lad_in = 4'hF; step();
    lad_in = 4'h0; step();
    if (answer != 0) begin
      exp_q.push_back(4'h0);            tag_q.push_back("R3 sync");
      exp_q.push_back(byte_exp[3:0]);   tag_q.push_back(answer == 1 ? "R4 low nibble" : "R8 low nibble");
      exp_q.push_back(byte_exp[7:4]);   tag_q.push_back(answer == 1 ? "R4 high nibble" : "R8 high nibble");
      exp_q.push_back(4'hF);            tag_q.push_back("R5 tail ones");
    end
    step();                 // cycle 10
    step();                 // cycle 11
    if (wr_race) begin cpu_wr = 1'b1; cpu_wdata = 8'hE1; end
    step();                 // cycle 12
    cpu_wr = 1'b0;
    @(negedge clk);
    if (answer == 1) begin
      check("R6 irq in cycle 12", {7'd0, obuf_empty_irq}, 8'h01);
      check(wr_race ? "R7 write wins" : "R6 flag cleared", {7'd0, obuf_full},
            wr_race ? 8'h01 : 8'h00);
    end else begin
      check(answer == 2 ? "R8 no irq" : "R9 no irq", {7'd0, obuf_empty_irq}, 8'h00);
      check(answer == 2 ? "R8 flag kept" : "R9 flag kept", {7'd0, obuf_full},
            {7'd0, flag_before});
    end
    step();                 // cycle 13
    @(negedge clk);
    check("R5 released in cycle 13", {7'd0, lad_oe}, 8'h00);
    check("R6 irq one clock", {7'd0, obuf_empty_irq}, 8'h00);
    step();
  endtask

  initial begin
    rst_n = 1'b0; lframe_n = 1'b1; lad_in = 4'hF;
    cpu_wr = 1'b0; cpu_wdata = 8'h00; status_hi = 7'h2A;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 oe in reset", {7'd0, lad_oe}, 8'h00);
    check("R1 flag in reset", {7'd0, obuf_full}, 8'h00);
    rst_n = 1'b1;
    step();
    @(negedge clk);
    check("R1 irq after reset", {7'd0, obuf_empty_irq}, 8'h00);
    check("R1 flag after reset", {7'd0, obuf_full}, 8'h00);
    step();

    // R2 R4 R6: data port read, type nibble with bit 0 set
    cpu_write(8'hA5);
    host_read(4'h0, 4'h1, DPORT, 1, 8'hA5, 1'b0);
    // R8: status with flag clear -> {2A,0} = 54
    host_read(4'h0, 4'h0, SPORT, 2, 8'h54, 1'b0);
    // R8: status with flag set -> 55, flag stays set
    cpu_write(8'h3C);
    host_read(4'h0, 4'h0, SPORT, 2, 8'h55, 1'b0);
    host_read(4'h0, 4'h0, DPORT, 1, 8'h3C, 1'b0);
    // R9: nibble-reversed address, then a valid read
    cpu_write(8'h77);
    host_read(4'h0, 4'h0, 16'h0600, 0, 8'h00, 1'b0);
    // R10: write cycle type to data port
    host_read(4'h0, 4'h2, DPORT, 0, 8'h00, 1'b0);
    // R11: wrong start code
    host_read(4'h5, 4'h0, DPORT, 0, 8'h00, 1'b0);
    check("R9 flag still set", {7'd0, obuf_full}, 8'h01);
    host_read(4'h0, 4'h0, DPORT, 1, 8'h77, 1'b0);
    // R7: local write on the closing edge of a data read
    cpu_write(8'h9B);
    host_read(4'h0, 4'h0, DPORT, 1, 8'h9B, 1'b1);
    host_read(4'h0, 4'h0, DPORT, 1, 8'hE1, 1'b0);

    check("R3 scoreboard drained", 8'(exp_q.size()), 8'h00);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule